// File: doc/BRIEF.md
# Word-to-Byte Bus Access Sequencer

This block sits between a 16-bit internal data path and a narrow external memory bus that moves one byte per transfer over a 20-bit byte address. An internal agent hands it a read or write request, either a full word or a single byte. A word request becomes two back-to-back byte transfers on the external bus. The first transfer moves the low byte at the given address. The second moves the high byte at the next address, which wraps around the top of the 20-bit space. On a word read the two bytes are reassembled little-endian. A byte request makes one transfer, and a byte read is zero-extended to 16 bits.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so the requester is held off for the whole access and for the single completion cycle after it. The requester must keep its request fields stable while `req_valid` is high and `req_ready` is low. Completion is reported by `rsp_valid`, which pulses for one cycle and cannot be stalled. The external side uses plain strobes. A transfer stays on the bus while `bus_wait` is high and completes on the first rising edge with `bus_wait` low.

Top module: `word_byte_bridge`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `req_ready` is 1 and `bus_rd`, `bus_wr` and `rsp_valid` are 0. Reset in the middle of an access abandons it and returns the block to idle.
- R2: `req_ready` is 1 only when no access is in progress and no completion is being signalled. A request is accepted on an edge with `req_valid` and `req_ready` both high. No strobe is active while `req_ready` is 1.
- R3: A word request (`req_word`=1) makes exactly two transfers. The first is at `req_addr` and carries bits [7:0]. The second is at `req_addr`+1 and carries bits [15:8].
- R4: A byte request (`req_word`=0) makes exactly one transfer, at `req_addr`. On a write that transfer drives `req_wdata[7:0]`, and the byte at `req_addr`+1 is left unchanged.
- R5: A word read returns `rsp_rdata` = {byte at addr+1, byte at addr}. A byte read returns {8'h00, byte at addr}.
- R6: While `bus_wait` is 1 during a transfer, the address, the strobe and the write data hold steady. The transfer completes on the first edge with `bus_wait` low.
- R7: `rsp_valid` is 1 for exactly one cycle, the cycle right after the final transfer completes. Counted from the accepting edge, it is seen n*(1+w)+1 cycles later, where n is the number of transfers and w is the number of wait cycles per transfer.
- R8: `bus_rd` and `bus_wr` are never 1 in the same cycle. `bus_wr` is used for write requests (`req_write`=1) and `bus_rd` for read requests.
- R9: The address of the second transfer is computed modulo 2^20, so a word at 20'hFFFFF puts its high byte at 20'h00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | 20 | Byte address of the access |
| req_wdata | input | 16 | Write data; bits [7:0] only for a byte access |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid while `rsp_valid` is 1 |
| bus_addr | output | 20 | External byte address |
| bus_wdata | output | 8 | External write byte |
| bus_rdata | input | 8 | External read byte |
| bus_rd | output | 1 | External read strobe |
| bus_wr | output | 1 | External write strobe |
| bus_wait | input | 1 | External stretch request |

## Verification
The bench builds the block with its default widths: a 20-bit address and 8-bit lanes, which give a 16-bit word. At these widths the wrap from 20'hFFFFF to 20'h00000 can be reached directly, and the bench does so with both a word write and a word read. Its byte memory model decodes only the low eight address bits, so the wrapped second byte and a word at a low address can be checked against each other. The per-transfer wait count is varied from zero to three, which covers both the immediate-completion path and long stretched transfers, including a reset that arrives during a stretched transfer.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_DONE = 2'd3
  } wbb_state_e;
endpackage

// File: rtl/wbb_seq.sv
module wbb_seq
  import wbb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic req_word,
  input  logic bus_wait,
  output logic idle,
  output logic busy,
  output logic xfer_done,
  output logic lane_idx,
  output logic done
);
  wbb_state_e state_q, state_d;
  logic       word_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_fire) state_d = ST_LO;
      ST_LO:   if (!bus_wait) state_d = word_q ? ST_HI : ST_DONE;
      ST_HI:   if (!bus_wait) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_fire) word_q <= req_word;
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign busy      = (state_q == ST_LO) || (state_q == ST_HI);
  assign xfer_done = busy && !bus_wait;
  assign lane_idx  = (state_q == ST_HI);
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/wbb_lanes.sv
module wbb_lanes #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_fire,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*BYTE_W-1:0] req_wdata,
  input  logic                lane_idx,
  input  logic                xfer_done,
  input  logic [BYTE_W-1:0]   bus_rdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [BYTE_W-1:0]   bus_wdata,
  output logic                write_q,
  output logic [2*BYTE_W-1:0] rsp_rdata
);
  localparam int LANES  = 2;
  localparam int WORD_W = LANES * BYTE_W;

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (req_fire) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  // Lane 1 is only reached in the high phase, so a byte read leaves it cleared.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] rd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rd_q <= '0;
      else if (req_fire)
        rd_q <= '0;
      else if (xfer_done && (lane_idx == g[0]))
        rd_q <= bus_rdata;
    end
    assign rsp_rdata[g*BYTE_W +: BYTE_W] = rd_q;
  end

  // The add truncates to ADDR_W bits, which gives the wrap at the top of the space.
  assign bus_addr  = addr_q + {{(ADDR_W-1){1'b0}}, lane_idx};
  assign bus_wdata = lane_idx ? wdata_q[WORD_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
endmodule

// File: rtl/word_byte_bridge.sv
module word_byte_bridge #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*BYTE_W-1:0] req_wdata,
  output logic                rsp_valid,
  output logic [2*BYTE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [BYTE_W-1:0]   bus_wdata,
  input  logic [BYTE_W-1:0]   bus_rdata,
  output logic                bus_rd,
  output logic                bus_wr,
  input  logic                bus_wait
);
  logic idle, busy, xfer_done, lane_idx, write_q, req_fire;

  assign req_ready = idle;
  assign req_fire  = req_valid && idle;

  wbb_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .req_word  (req_word),
    .bus_wait  (bus_wait),
    .idle      (idle),
    .busy      (busy),
    .xfer_done (xfer_done),
    .lane_idx  (lane_idx),
    .done      (rsp_valid)
  );

  wbb_lanes #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .lane_idx  (lane_idx),
    .xfer_done (xfer_done),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .write_q   (write_q),
    .rsp_rdata (rsp_rdata)
  );

  assign bus_rd = busy && !write_q;
  assign bus_wr = busy && write_q;
endmodule

// File: rtl/wbb_checker.sv
module wbb_checker #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_wait
);
  logic strobe;
  assign strobe = bus_rd || bus_wr;

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_quiet_when_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !strobe);

  p_not_ready_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_hold_on_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && bus_wait) |=> ($stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr)
                              && (!bus_wr || $stable(bus_wdata))));

  // R3 and R9: a transfer that directly follows a finished one is the high byte at addr+1.
  p_next_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !bus_wait) |=> (!strobe || (bus_addr == ADDR_W'($past(bus_addr) + 1'b1))));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_done_follows_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !bus_wait) |=> (rsp_valid || strobe));
endmodule

bind word_byte_bridge wbb_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_wbb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wait  (bus_wait)
);

// File: tb/test_word_byte_bridge.sv
module test_word_byte_bridge;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic        wd;
    logic [19:0] a;
    logic [15:0] d;
    logic [1:0]  w;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    vec_t'{1'b0, 1'b1, 20'h18000, 16'h0000, 2'd0},
    vec_t'{1'b1, 1'b1, 20'h18000, 16'h5A2F, 2'd0},
    vec_t'{1'b0, 1'b1, 20'h18000, 16'h0000, 2'd1},
    vec_t'{1'b0, 1'b0, 20'h18001, 16'h0000, 2'd0},
    vec_t'{1'b1, 1'b0, 20'h00420, 16'h77C3, 2'd2},
    vec_t'{1'b0, 1'b1, 20'h0041F, 16'h0000, 2'd0},
    vec_t'{1'b1, 1'b1, 20'hFFFFF, 16'h1234, 2'd1},
    vec_t'{1'b0, 1'b1, 20'hFFFFF, 16'h0000, 2'd0},
    vec_t'{1'b0, 1'b0, 20'h00000, 16'h0000, 2'd3},
    vec_t'{1'b1, 1'b0, 20'h00003, 16'hABCD, 2'd0},
    vec_t'{1'b0, 1'b1, 20'h00003, 16'h0000, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, bus_rd, bus_wr, bus_wait;
  logic [15:0] rsp_rdata;
  logic [19:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  logic [7:0]  mem [256];
  logic [7:0]  sh  [256];
  int          wcnt = 0;
  int          cur_wait = 0;
  int          log_n = 0;
  logic [19:0] log_a [4];
  logic        log_w [4];
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  word_byte_bridge i_word_byte_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wait(bus_wait)
  );

  assign bus_rdata = mem[bus_addr[7:0]];
  assign bus_wait  = (wcnt < cur_wait);

  // Byte memory model with programmable stretch; logs each finished transfer.
  always @(posedge clk) begin
    if (!rst_n) wcnt <= 0;
    else if (bus_rd || bus_wr) begin
      if (bus_wait) wcnt <= wcnt + 1;
      else begin
        wcnt <= 0;
        if (log_n < 4) begin
          log_a[log_n] <= bus_addr;
          log_w[log_n] <= bus_wr;
        end
        log_n <= log_n + 1;
        if (bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int cyc;
    int n;
    logic [19:0] a1;
    logic [15:0] exp;
    n  = v.wd ? 2 : 1;
    a1 = v.a + 20'd1;
    @(negedge clk);
    cur_wait  = v.w;
    log_n     = 0;
    req_valid = 1'b1; req_write = v.wr; req_word = v.wd;
    req_addr  = v.a;  req_wdata = v.d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready low while busy", {31'd0, req_ready}, 32'd0);
    cyc = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == n*(1+v.w)+1, "R7/R6 completion latency", cyc, n*(1+v.w)+1);
    chk(log_n == n, v.wd ? "R3 word transfer count" : "R4 byte transfer count", log_n, n);
    chk(log_a[0] == v.a, "R3 first address", log_a[0], v.a);
    chk(log_w[0] == v.wr, "R8 strobe kind", {31'd0, log_w[0]}, {31'd0, v.wr});
    if (v.wd) chk(log_a[1] == a1, "R9 second address wraps", log_a[1], a1);
    if (v.wr) begin
      sh[v.a[7:0]] = v.d[7:0];
      if (v.wd) sh[a1[7:0]] = v.d[15:8];
    end else begin
      exp = v.wd ? {sh[a1[7:0]], sh[v.a[7:0]]} : {8'h00, sh[v.a[7:0]]};
      chk(rsp_rdata == exp, v.wd ? "R5 word assembly" : "R5 byte zero-extend", rsp_rdata, exp);
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R7 single-cycle done", {30'd0, rsp_valid, req_ready}, 32'd1);
    if (v.wr) begin
      chk(mem[v.a[7:0]] == sh[v.a[7:0]], "R3 low byte stored", mem[v.a[7:0]], sh[v.a[7:0]]);
      chk(mem[a1[7:0]] == sh[a1[7:0]], v.wd ? "R3 high byte stored" : "R4 neighbour untouched",
          mem[a1[7:0]], sh[a1[7:0]]);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      sh[i]  = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_rd && !bus_wr && !rsp_valid, "R1 reset state",
        {28'd0, req_ready, bus_rd, bus_wr, rsp_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_rd && !bus_wr && !rsp_valid, "R1 idle after reset",
        {28'd0, req_ready, bus_rd, bus_wr, rsp_valid}, 32'h8);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R6: check the address holds during a stretched transfer.
    @(negedge clk);
    cur_wait = 3; log_n = 0;
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = 20'h00050;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_rd && bus_wait && bus_addr == 20'h00050, "R6 stretched transfer active",
        bus_addr, 20'h00050);
    @(negedge clk);
    chk(bus_rd && bus_addr == 20'h00050, "R6 address held under wait", bus_addr, 20'h00050);
    // R1: a reset in the middle of the access abandons it.
    rst_n = 1'b0;
    #1;
    chk(req_ready && !bus_rd && !bus_wr && !rsp_valid, "R1 reset mid-access",
        {28'd0, req_ready, bus_rd, bus_wr, rsp_valid}, 32'h8);
    @(negedge clk);
    rst_n = 1'b1;
    cur_wait = 0;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 idle after mid-access reset",
        {30'd0, req_ready, rsp_valid}, 32'h2);

    run_vec(vec_t'{1'b0, 1'b1, 20'h00050, 16'h0000, 2'd0});
    summary();
  end
endmodule